// File: doc/BRIEF.md
# Minimum-Rank Descriptor Scheduler

This block is a push-in first-out queue for packet descriptors. A producer pushes one descriptor per handshake: a rank and a 32-bit metadata word. The metadata word holds the packet length and the source and destination port codes. The scheduler keeps its entries sorted by rank. Its output always offers the stored descriptor with the smallest rank, and arrival order decides between equal ranks.

After reset the block clears its storage, one entry per cycle, and holds `busy` high for that time. Each accepted descriptor then needs one settling cycle to reach its sorted place, and `busy` is high during that cycle too. While `busy` is high the block takes no new descriptor and offers none. If a descriptor is accepted in a cycle where the output could also have been taken, the insertion wins. That descriptor can therefore be the next one to leave. An empty flag and an occupancy count are also exported.

Top module: `pifo_rank_scheduler`

## Requirements
- R1: While reset is asserted and for exactly DEPTH clock cycles after it is released, `busy` is high, `in_ready` is low and `out_valid` is low.
- R2: After reset `occupancy` is 0 and `empty` is 1. `empty` is 1 exactly when `occupancy` is 0, and `occupancy` always equals the number of descriptors stored and not yet removed.
- R3: When `out_valid` is high, `out_rank` is the smallest rank among the stored descriptors. With no insertion between them, successive removals leave in non-decreasing rank order (ranks are unsigned).
- R4: Among stored descriptors of equal rank, the one accepted earlier is offered first.
- R5: Every accepted descriptor leaves exactly once, with `out_meta` equal bit for bit to the `in_meta` it entered with. The metadata word is laid out as follows:
  - bits 31:16 hold the length;
  - bits 15:8 hold the source port code;
  - bits 7:0 hold the destination port code.
  A port code is one-hot on even bits: port 0 is bit 0, port 1 is bit 2, port 2 is bit 4 and port 3 is bit 6.
- R6: A descriptor is accepted on a cycle where `in_valid` and `in_ready` are both high. `busy` is high for exactly the next cycle, and `occupancy` rises by one at the end of that cycle.
- R7: When `occupancy` equals DEPTH, `in_ready` is low and no descriptor is taken.
- R8: While `out_ready` is low and no descriptor is accepted, `out_valid`, `out_rank` and `out_meta` hold their values.
- R9: In a cycle where a descriptor is accepted, `out_valid` is low. The accepted descriptor is therefore sorted in before the next removal, and it leaves first if its rank is the smallest.
- R10: A descriptor is removed only in a cycle where `out_valid` and `out_ready` are both high, and `occupancy` then falls by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | Producer offers a descriptor |
| in_ready | output | 1 | Scheduler can take a descriptor this cycle |
| in_rank | input | 8 | Rank of the offered descriptor; lower leaves earlier |
| in_meta | input | 32 | Metadata of the offered descriptor (length, source code, destination code) |
| out_valid | output | 1 | The minimum-rank descriptor is on offer |
| out_ready | input | 1 | Consumer takes the offered descriptor |
| out_rank | output | 8 | Rank of the offered descriptor |
| out_meta | output | 32 | Metadata of the offered descriptor |
| busy | output | 1 | Storage clear after reset or insertion settling in progress |
| empty | output | 1 | No descriptor stored |
| occupancy | output | 5 | Number of stored descriptors |

## Verification
The assertions take three things for granted about the inputs:
- `rst_n` is deasserted in step with the clock;
- `in_valid` and `out_ready` are never unknown once reset is released;
- ranks are read as unsigned numbers.

They do not require the producer to hold its data steady before acceptance. The stimulus still does so: every input changes just after a rising edge, reset is released there too, and a descriptor stays on the bus until the cycle `in_ready` is seen high. Ranks stay within 0 to 100 and port codes within the four legal one-hot values. Back-pressure is varied from nearly constant to rare, so that the queue both fills to its limit and drains empty.

// File: rtl/pifo_pkg.sv
package pifo_pkg;

  localparam int RANK_W = 8;
  localparam int LEN_W  = 16;
  localparam int PORT_W = 8;
  localparam int META_W = LEN_W + 2 * PORT_W;

  // One stored entry: rank used for ordering, metadata carried untouched.
  typedef struct packed {
    logic [RANK_W-1:0] rank;
    logic [META_W-1:0] meta;
  } pifo_desc_t;

endpackage

// File: rtl/pifo_init_seq.sv
// Walks every storage slot once after reset so the array holds known data.
module pifo_init_seq #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             active,
  output logic [IDX_W-1:0] idx
);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (idx_q == IDX_W'(DEPTH - 1)) begin
      act_d = 1'b0;
    end else begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;

endmodule

// File: rtl/pifo_slot_select.sv
// Finds the slot a new rank belongs in: after every stored entry whose rank
// is lower or equal, so equal ranks keep arrival order.
module pifo_slot_select import pifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [RANK_W-1:0] rank_key [DEPTH],
  input  logic [CNT_W-1:0]  fill,
  input  logic [RANK_W-1:0] new_rank,
  output logic [CNT_W-1:0]  pos
);

  logic [DEPTH-1:0] ahead;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign ahead[i] = (CNT_W'(i) < fill) && (rank_key[i] <= new_rank);
    end
  endgenerate

  // The array is sorted, so 'ahead' is a thermometer code; its population
  // count is the insertion index.
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = pos + CNT_W'(ahead[i]);
    end
  end

endmodule

// File: rtl/pifo_sorted_store.sv
// Rank-sorted register array, slot 0 is the head.
// An insert shifts the tail up from the chosen slot; a removal shifts all down.
module pifo_sorted_store import pifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              ins_en,
  input  logic [CNT_W-1:0]  ins_pos,
  input  pifo_desc_t        ins_desc,
  input  logic              deq_en,
  output pifo_desc_t        head,
  output logic [RANK_W-1:0] rank_key [DEPTH]
);

  pifo_desc_t       slot_q [DEPTH];
  pifo_desc_t       slot_d [DEPTH];
  pifo_desc_t       from_above [DEPTH];
  pifo_desc_t       from_below [DEPTH];
  logic [DEPTH-1:0] slot_en;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_nbr
      if (i == DEPTH - 1) begin : g_last
        assign from_above[i] = slot_q[i];
      end else begin : g_inner
        assign from_above[i] = slot_q[i+1];
      end
      if (i == 0) begin : g_first
        assign from_below[i] = ins_desc;
      end else begin : g_rest
        assign from_below[i] = slot_q[i-1];
      end
      assign rank_key[i] = slot_q[i].rank;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_d[i]  = slot_q[i];
      slot_en[i] = 1'b0;
      if (clr_en && (clr_idx == IDX_W'(i))) begin
        slot_d[i]  = '0;
        slot_en[i] = 1'b1;
      end else if (ins_en && (ins_pos <= CNT_W'(i))) begin
        slot_d[i]  = (ins_pos == CNT_W'(i)) ? ins_desc : from_below[i];
        slot_en[i] = 1'b1;
      end else if (deq_en) begin
        slot_d[i]  = from_above[i];
        slot_en[i] = 1'b1;
      end
    end
  end

  // Data storage carries no reset; the clear walk gives it known contents.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_en[i]) slot_q[i] <= slot_d[i];
    end
  end

  assign head = slot_q[0];

endmodule

// File: rtl/pifo_rank_scheduler.sv
module pifo_rank_scheduler import pifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [META_W-1:0] in_meta,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RANK_W-1:0] out_rank,
  output logic [META_W-1:0] out_meta,
  output logic              busy,
  output logic              empty,
  output logic [CNT_W-1:0]  occupancy
);

  logic              clr_active;
  logic [IDX_W-1:0]  clr_idx;
  logic              hold_v_q, hold_v_d;
  pifo_desc_t        hold_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  ins_pos;
  logic [RANK_W-1:0] rank_key [DEPTH];
  pifo_desc_t        head;
  logic              full, accept, deq;

  pifo_init_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (clr_active),
    .idx    (clr_idx)
  );

  pifo_slot_select #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_select (
    .rank_key (rank_key),
    .fill     (cnt_q),
    .new_rank (hold_q.rank),
    .pos      (ins_pos)
  );

  pifo_sorted_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_store (
    .clk      (clk),
    .clr_en   (clr_active),
    .clr_idx  (clr_idx),
    .ins_en   (hold_v_q),
    .ins_pos  (ins_pos),
    .ins_desc (hold_q),
    .deq_en   (deq),
    .head     (head),
    .rank_key (rank_key)
  );

  // Handshake: an accepted descriptor withholds the output in the same
  // cycle, so it is sorted in before any removal can happen.
  assign busy      = clr_active | hold_v_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign in_ready  = !busy && !full;
  assign accept    = in_valid && in_ready;
  assign out_valid = (cnt_q != '0) && !busy && !accept;
  assign deq       = out_valid && out_ready;

  // Insertion (settling cycle) and removal never coincide: removal needs !busy.
  always_comb begin
    hold_v_d = accept;
    cnt_d    = cnt_q;
    if (hold_v_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (deq) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (hold_v_q || deq) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) hold_q <= '{rank: in_rank, meta: in_meta};
  end

  assign out_rank  = head.rank;
  assign out_meta  = head.meta;
  assign empty     = (cnt_q == '0);
  assign occupancy = cnt_q;

endmodule

// File: rtl/pifo_rank_scheduler_chk.sv
module pifo_rank_scheduler_chk import pifo_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [RANK_W-1:0] out_rank,
  input logic [META_W-1:0] out_meta,
  input logic              busy,
  input logic              empty,
  input logic [CNT_W-1:0]  occupancy
);

  logic [RANK_W-1:0] last_rank_q;
  logic              have_last_q;

  // Rank of the previous removal, forgotten whenever a descriptor enters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rank_q <= '0;
      have_last_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      have_last_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_rank_q <= out_rank;
      have_last_q <= 1'b1;
    end
  end

  a_r1_busy_gates: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !out_valid));

  a_r2_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!out_valid && occupancy == '0));

  a_r3_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_last_q) |-> (out_rank >= last_rank_q));

  a_r6_settle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r7_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> !in_ready);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(in_valid && in_ready)) |=>
      ((in_valid && in_ready) ||
       (out_valid && $stable(out_rank) && $stable(out_meta))));

  a_r9_insert_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !out_valid);

  a_r10_remove_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (occupancy == $past(occupancy) - CNT_W'(1)));

endmodule

bind pifo_rank_scheduler pifo_rank_scheduler_chk #(.DEPTH(DEPTH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rank  (out_rank),
  .out_meta  (out_meta),
  .busy      (busy),
  .empty     (empty),
  .occupancy (occupancy)
);

// File: tb/test_pifo_rank_scheduler.sv
`timescale 1ns/1ps
module test_pifo_rank_scheduler;

  localparam int DEPTH = 16;

  typedef struct packed {
    logic [7:0]  rank;
    logic [31:0] meta;
  } ent_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_rank;
  logic [31:0] in_meta;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_rank;
  logic [31:0] out_meta;
  logic        busy;
  logic        empty;
  logic [4:0]  occupancy;

  int n_checks = 0;
  int n_fail   = 0;
  int n_in     = 0;
  int n_out    = 0;

  pifo_rank_scheduler #(.DEPTH(DEPTH)) i_pifo_rank_scheduler (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_rank(in_rank), .in_meta(in_meta),
    .out_valid(out_valid), .out_ready(out_ready), .out_rank(out_rank), .out_meta(out_meta),
    .busy(busy), .empty(empty), .occupancy(occupancy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  ent_t mq[$];
  int   init_left;
  bit   pend_v;
  ent_t pend;
  bit   e_busy, e_full, e_inr, e_acc, e_ov;
  int   ins_idx;

  always @(negedge clk) begin
    if (!rst_n) begin
      init_left = DEPTH;
      mq.delete();
      pend_v = 1'b0;
    end else begin
      e_busy = (init_left > 0) || pend_v;
      e_full = (mq.size() == DEPTH);
      e_inr  = !e_busy && !e_full;
      e_acc  = in_valid && e_inr;
      e_ov   = (mq.size() > 0) && !e_busy && !e_acc;
      chk(busy === e_busy, "R1 R6 busy", busy, e_busy);
      chk(in_ready === e_inr, "R7 in_ready", in_ready, e_inr);
      chk(out_valid === e_ov, "R9 R10 out_valid", out_valid, e_ov);
      chk(occupancy == mq.size(), "R2 R10 occupancy", occupancy, mq.size());
      chk(empty === (mq.size() == 0), "R2 empty", empty, mq.size() == 0);
      if (e_ov) begin
        chk(out_rank == mq[0].rank, "R3 R4 out_rank", out_rank, mq[0].rank);
        chk(out_meta == mq[0].meta, "R5 out_meta", out_meta, mq[0].meta);
      end
      // advance the model to the state after the coming rising edge
      if (init_left > 0) init_left--;
      if (pend_v) begin
        ins_idx = 0;
        for (int k = 0; k < mq.size(); k++) if (mq[k].rank <= pend.rank) ins_idx = k + 1;
        mq.insert(ins_idx, pend);
        pend_v = 1'b0;
      end
      if (e_acc) begin
        pend   = {in_rank, in_meta};
        pend_v = 1'b1;
        n_in++;
      end
      if (e_ov && out_ready) begin
        void'(mq.pop_front());
        n_out++;
      end
    end
  end

  logic [7:0]  got_rank[$];
  logic [31:0] got_meta[$];

  function automatic logic [31:0] mk(input int len, input int s, input int d);
    return {16'(len), 8'(1 << (2 * s)), 8'(1 << (2 * d))};
  endfunction

  task automatic push(input logic [7:0] r, input logic [31:0] m);
    in_valid = 1'b1; in_rank = r; in_meta = m;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic pop_n(input int n);
    got_rank.delete(); got_meta.delete();
    out_ready = 1'b1;
    while (got_rank.size() < n) begin
      @(negedge clk);
      if (out_valid) begin
        got_rank.push_back(out_rank);
        got_meta.push_back(out_meta);
      end
      @(posedge clk); #1;
    end
    out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n_busy;
    int ranks[8] = '{50, 3, 99, 3, 0, 77, 100, 3};
    bit acc;
    int last_len;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_rank = '0; in_meta = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(occupancy == 0, "R2 reset occupancy", occupancy, 0);
    chk(empty == 1'b1, "R2 reset empty", empty, 1);
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: busy length after release
    n_busy = 0;
    repeat (DEPTH + 3) begin @(negedge clk); if (busy) n_busy++; end
    chk(n_busy == DEPTH, "R1 init busy cycles", n_busy, DEPTH);
    @(posedge clk); #1;

    // R3 R4 R5: mixed ranks with a three-way tie, legal port codes
    for (int i = 0; i < 8; i++) push(8'(ranks[i]), mk(i, i % 4, (i + 1) % 4));
    idle(2);
    pop_n(8);
    for (int i = 1; i < 8; i++)
      chk(got_rank[i] >= got_rank[i-1], "R3 drain order", got_rank[i], got_rank[i-1]);
    last_len = -1;
    for (int i = 0; i < 8; i++) begin
      if (got_rank[i] == 8'd3) begin
        chk(int'(got_meta[i][31:16]) > last_len, "R4 tie order", got_meta[i][31:16], last_len + 1);
        last_len = int'(got_meta[i][31:16]);
      end
    end

    // R7: fill completely, extra push refused
    for (int i = 0; i < DEPTH; i++) push(8'((DEPTH - i) * 5), mk(100 + i, 0, 3));
    idle(2);
    in_valid = 1'b1; in_rank = 8'd1; in_meta = mk(999, 1, 2);
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 full in_ready", in_ready, 0);
      chk(occupancy == DEPTH, "R7 full occupancy", occupancy, DEPTH);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    pop_n(DEPTH);
    chk(got_rank[0] == 8'd5, "R3 full head", got_rank[0], 5);

    // R8: stalled head holds
    push(8'd9, mk(1, 2, 1));
    push(8'd7, mk(2, 3, 0));
    idle(2);
    repeat (4) begin
      @(negedge clk);
      chk(out_valid && out_rank == 8'd7, "R8 held rank", out_rank, 7);
      chk(out_meta == mk(2, 3, 0), "R8 held meta", out_meta, mk(2, 3, 0));
    end
    @(posedge clk); #1;
    push(8'd1, mk(3, 0, 0));
    idle(1);
    pop_n(3);
    chk(got_rank[0] == 8'd1 && got_rank[1] == 8'd7 && got_rank[2] == 8'd9,
        "R3 after stall", got_rank[0], 1);

    // R9: accept and ready in the same cycle, new smaller rank leaves first
    push(8'd40, mk(4, 1, 1));
    idle(2);
    in_valid = 1'b1; in_rank = 8'd5; in_meta = mk(5, 2, 2); out_ready = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 accepted", in_ready, 1);
    chk(out_valid == 1'b0, "R9 output withheld", out_valid, 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    pop_n(2);
    chk(got_rank[0] == 8'd5, "R9 new entry first", got_rank[0], 5);
    chk(got_meta[0] == mk(5, 2, 2), "R5 new entry meta", got_meta[0], mk(5, 2, 2));

    // Random traffic, heavy then light back-pressure
    acc = 1'b1;
    for (int ph = 0; ph < 2; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        if (!in_valid || acc) begin
          in_valid = ($urandom_range(2, 0) != 0);
          in_rank  = 8'($urandom_range(100, 0));
          in_meta  = mk(int'($urandom_range(1500, 40)), int'($urandom_range(3, 0)),
                        int'($urandom_range(3, 0)));
        end
        out_ready = (ph == 0) ? ($urandom_range(3, 0) == 0) : ($urandom_range(3, 0) != 0);
        @(negedge clk);
        acc = in_valid && in_ready;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(4 * DEPTH + 8);
    out_ready = 1'b0;
    @(negedge clk);
    chk(occupancy == 0 && empty, "R2 drained", occupancy, 0);
    chk(n_in == n_out, "R5 no loss or duplicate", n_out, n_in);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule